// File: doc/BRIEF.md
# Mailbox Protocol Discovery Responder

This block sits behind a config-space mailbox and answers the discovery exchange. A requester uses that exchange to learn which protocols the mailbox serves. The front end unpacks the request into three dwords and pulses `start`: the first header dword, the second header dword and the body dword holding an index. Two clocks later the responder pulses `done` and presents a three-dword reply. The reply names one supported vendor/protocol pair and the index of the pair that follows it.

The list of supported pairs is fixed at elaboration through a packed parameter, one 24-bit entry per pair. A requester starts at index 0 and follows the returned next index until it receives 0, which marks the end of the list. A request whose header does not identify a discovery object is answered with a reject flag and an all-zero reply.

Top module: `disc_responder`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `done` and `reject` are 0. All three response dwords are 0 until the first reply.
- R2: A request is accepted when three fields match: header dword 1 bits 15:0 equal 0x0001, header dword 1 bits 23:16 equal 0x00, and header dword 2 bits 17:0 (length in dwords) equal 3. An accepted request gives `reject` = 0.
- R3: Any other vendor, type or length gives `reject` = 1, and `rsp_hdr1`, `rsp_hdr2` and `rsp_body` are all 0.
- R4: An accepted request gets `rsp_hdr1` = 0x00000001 (vendor 0x0001, type 0) and `rsp_hdr2` = 0x00000003 (length 3).
- R5: For an accepted request, `rsp_body` describes the table entry selected by body bits 7:0. Bits 15:0 hold that entry's vendor ID, bits 23:16 its protocol number and bits 31:24 the next index.
- R6: The next index is the requested index plus one, except for the last table entry, whose next index is 0.
- R7: An index at or beyond the table size returns entry 0 with the next index that entry 0 carries (1, or 0 if the table has a single entry).
- R8: `done` is a one-cycle pulse that is visible in the second cycle after the clock edge sampling `start`. The response outputs and `reject` change only in a cycle where `done` is high.
- R9: Starts on consecutive cycles each produce their own `done` pulse, in order, on consecutive cycles.
- R10: Reserved bits are ignored: header dword 1 bits 31:24, header dword 2 bits 31:18 and body bits 31:8.
- R11: Without `start`, changing the request inputs produces no `done` and leaves the response outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse: request inputs are valid |
| req_hdr1 | input | 32 | Request header dword 1 (vendor, type) |
| req_hdr2 | input | 32 | Request header dword 2 (length) |
| req_body | input | 32 | Request body dword (index in bits 7:0) |
| done | output | 1 | One-cycle pulse: reply is valid |
| reject | output | 1 | Last request was not a discovery object |
| rsp_hdr1 | output | 32 | Reply header dword 1 |
| rsp_hdr2 | output | 32 | Reply header dword 2 |
| rsp_body | output | 32 | Reply body: vendor, protocol, next index |

## Verification
Each index inside the table is requested, and a full walk separates a correct next-index chain from an off-by-one or from a last entry that fails to wrap to 0. Indices just past the end, far past it and 0xFF separate the fallback to entry 0 from a truncated compare. Headers that are wrong in one field at a time show that each of vendor, type and length is checked on its own. A length with only high bits set and requests full of reserved ones show that only the defined field widths are compared. Back-to-back starts and input changes without a start show the pipeline timing and that the held reply stays put.

// File: rtl/disc_resp_pkg.sv
package disc_resp_pkg;

    localparam logic [15:0] DISC_VID  = 16'h0001;
    localparam logic [7:0]  DISC_TYPE = 8'h00;
    localparam logic [17:0] DISC_LEN  = 18'd3;
    localparam int          ENTRY_W   = 24;
    localparam int          IDX_W     = 8;

    typedef struct packed {
        logic [15:0] vid;
        logic [7:0]  otype;
        logic [17:0] len;
        logic [7:0]  idx;
    } disc_req_t;

    typedef struct packed {
        logic [7:0]  prot;
        logic [15:0] vid;
    } proto_entry_t;

    typedef struct packed {
        logic [31:0] hdr1;
        logic [31:0] hdr2;
        logic [31:0] body;
    } disc_rsp_t;

    function automatic logic [31:0] make_body(proto_entry_t e, logic [IDX_W-1:0] nxt);
        return {nxt, e.prot, e.vid};
    endfunction

endpackage

// File: rtl/disc_req_check.sv
module disc_req_check
    import disc_resp_pkg::*;
(
    input  disc_req_t req,
    output logic      ok
);
    logic vid_ok;
    logic type_ok;
    logic len_ok;

    always_comb begin
        vid_ok  = (req.vid == DISC_VID);
        type_ok = (req.otype == DISC_TYPE);
        len_ok  = (req.len == DISC_LEN);
        ok      = vid_ok && type_ok && len_ok;
    end
endmodule

// File: rtl/disc_table_lookup.sv
module disc_table_lookup
    import disc_resp_pkg::*;
#(
    parameter int                            NUM_ENTRIES = 3,
    parameter logic [NUM_ENTRIES*ENTRY_W-1:0] PROTO_TABLE = '0
)(
    input  logic [IDX_W-1:0] idx,
    output proto_entry_t     entry,
    output logic [IDX_W-1:0] next_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    proto_entry_t     tbl [NUM_ENTRIES];
    logic [IDX_W-1:0] eff_idx;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_tbl
        assign tbl[g] = proto_entry_t'(PROTO_TABLE[g*ENTRY_W +: ENTRY_W]);
    end

    always_comb begin
        entry   = tbl[0];
        eff_idx = '0;
        for (int i = 1; i < NUM_ENTRIES; i++) begin
            if (idx == IDX_W'(i)) begin
                entry   = tbl[i];
                eff_idx = IDX_W'(i);
            end
        end
        next_idx = (eff_idx == LAST_IDX) ? '0 : eff_idx + 1'b1;
    end
endmodule

// File: rtl/disc_rsp_format.sv
module disc_rsp_format
    import disc_resp_pkg::*;
(
    input  logic             ok,
    input  proto_entry_t     entry,
    input  logic [IDX_W-1:0] next_idx,
    output disc_rsp_t        rsp,
    output logic             bad
);
    always_comb begin
        bad = !ok;
        if (ok) begin
            rsp.hdr1 = {8'h00, DISC_TYPE, DISC_VID};
            rsp.hdr2 = {14'h0, DISC_LEN};
            rsp.body = make_body(entry, next_idx);
        end else begin
            rsp = '0;
        end
    end
endmodule

// File: rtl/disc_responder.sv
module disc_responder
    import disc_resp_pkg::*;
#(
    parameter int                            NUM_ENTRIES = 3,
    parameter logic [NUM_ENTRIES*ENTRY_W-1:0] PROTO_TABLE =
        {24'h071ABC, 24'h021ABC, 24'h000001}
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] req_hdr1,
    input  logic [31:0] req_hdr2,
    input  logic [31:0] req_body,
    output logic        done,
    output logic        reject,
    output logic [31:0] rsp_hdr1,
    output logic [31:0] rsp_hdr2,
    output logic [31:0] rsp_body
);
    disc_req_t        req_in;
    logic             req_ok;
    logic             s1_valid;
    logic             s1_ok;
    logic [IDX_W-1:0] s1_idx;
    proto_entry_t     hit_entry;
    logic [IDX_W-1:0] hit_next;
    disc_rsp_t        rsp_next;
    logic             bad_next;
    disc_rsp_t        rsp_q;
    logic             done_q;
    logic             rej_q;
    logic             unused_rsvd;

    assign unused_rsvd = ^{req_hdr1[31:24], req_hdr2[31:18], req_body[31:8]};

    always_comb begin
        req_in.vid   = req_hdr1[15:0];
        req_in.otype = req_hdr1[23:16];
        req_in.len   = req_hdr2[17:0];
        req_in.idx   = req_body[7:0];
    end

    disc_req_check u_check (
        .req (req_in),
        .ok  (req_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_ok    <= 1'b0;
            s1_idx   <= '0;
        end else begin
            s1_valid <= start;
            if (start) begin
                s1_ok  <= req_ok;
                s1_idx <= req_in.idx;
            end
        end
    end

    disc_table_lookup #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .PROTO_TABLE (PROTO_TABLE)
    ) u_lookup (
        .idx      (s1_idx),
        .entry    (hit_entry),
        .next_idx (hit_next)
    );

    disc_rsp_format u_format (
        .ok       (s1_ok),
        .entry    (hit_entry),
        .next_idx (hit_next),
        .rsp      (rsp_next),
        .bad      (bad_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            rej_q  <= 1'b0;
            rsp_q  <= '0;
        end else begin
            done_q <= s1_valid;
            if (s1_valid) begin
                rej_q <= bad_next;
                rsp_q <= rsp_next;
            end
        end
    end

    assign done     = done_q;
    assign reject   = rej_q;
    assign rsp_hdr1 = rsp_q.hdr1;
    assign rsp_hdr2 = rsp_q.hdr2;
    assign rsp_body = rsp_q.body;
endmodule

// File: rtl/disc_responder_chk.sv
module disc_responder_chk #(
    parameter int NUM_ENTRIES = 3
)(
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        done,
    input logic        reject,
    input logic [31:0] rsp_hdr1,
    input logic [31:0] rsp_hdr2,
    input logic [31:0] rsp_body
);
    logic [1:0] start_sh;

    always_ff @(posedge clk) begin
        if (rst) start_sh <= '0;
        else     start_sh <= {start_sh[0], start};
    end

    // R1: reset clears the handshake outputs
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!done && !reject));

    // R8: done appears exactly two edges after start
    a_r8_done_timing: assert property (@(posedge clk) disable iff (rst)
        done == start_sh[1]);

    // R8: outputs hold between replies
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(rsp_body) && $stable(rsp_hdr1) && $stable(rsp_hdr2) && $stable(reject)));

    // R3: rejected replies are all zero
    a_r3_reject_zero: assert property (@(posedge clk) disable iff (rst)
        (done && reject) |-> (rsp_hdr1 == 32'h0 && rsp_hdr2 == 32'h0 && rsp_body == 32'h0));

    // R4: accepted reply header
    a_r4_header: assert property (@(posedge clk) disable iff (rst)
        (done && !reject) |-> (rsp_hdr1 == 32'h1 && rsp_hdr2 == 32'h3));

    // R6: next index never leaves the table
    a_r6_next_in_table: assert property (@(posedge clk) disable iff (rst)
        (done && !reject) |-> (int'(rsp_body[31:24]) < NUM_ENTRIES));
endmodule

bind disc_responder disc_responder_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .done     (done),
    .reject   (reject),
    .rsp_hdr1 (rsp_hdr1),
    .rsp_hdr2 (rsp_hdr2),
    .rsp_body (rsp_body)
);

// File: tb/sim_disc_responder.sv
module sim_disc_responder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] req_hdr1 = '0;
    logic [31:0] req_hdr2 = '0;
    logic [31:0] req_body = '0;
    logic        done;
    logic        reject;
    logic [31:0] rsp_hdr1;
    logic [31:0] rsp_hdr2;
    logic [31:0] rsp_body;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    disc_responder u0 (
        .clk(clk), .rst(rst), .start(start),
        .req_hdr1(req_hdr1), .req_hdr2(req_hdr2), .req_body(req_body),
        .done(done), .reject(reject),
        .rsp_hdr1(rsp_hdr1), .rsp_hdr2(rsp_hdr2), .rsp_body(rsp_body)
    );

    typedef struct packed {
        logic [31:0] h1;
        logic [31:0] h2;
        logic [31:0] body;
        logic        rej;
        logic [31:0] exp_body;
    } vec_t;

    localparam int NV = 13;
    // table: 0 -> 0001/00, 1 -> 1ABC/02, 2 -> 1ABC/07
    localparam vec_t VECS [NV] = '{
        '{32'h00000001, 32'h00000003, 32'h00000000, 1'b0, 32'h01000001}, // R5 idx0
        '{32'h00000001, 32'h00000003, 32'h00000001, 1'b0, 32'h02021ABC}, // R5 R6 idx1
        '{32'h00000001, 32'h00000003, 32'h00000002, 1'b0, 32'h00071ABC}, // R6 last wraps
        '{32'h00000001, 32'h00000003, 32'h00000003, 1'b0, 32'h01000001}, // R7 just past
        '{32'h00000001, 32'h00000003, 32'h00000041, 1'b0, 32'h01000001}, // R7 far
        '{32'h00000001, 32'h00000003, 32'h000000FF, 1'b0, 32'h01000001}, // R7 max
        '{32'hFF000001, 32'hFFFC0003, 32'hABCDEF01, 1'b0, 32'h02021ABC}, // R10 reserved
        '{32'h00000002, 32'h00000003, 32'h00000001, 1'b1, 32'h00000000}, // R3 vendor
        '{32'h00010001, 32'h00000003, 32'h00000001, 1'b1, 32'h00000000}, // R3 type
        '{32'h00000001, 32'h00000002, 32'h00000001, 1'b1, 32'h00000000}, // R3 len 2
        '{32'h00000001, 32'h00000004, 32'h00000001, 1'b1, 32'h00000000}, // R3 len 4
        '{32'h00000001, 32'h00030003, 32'h00000001, 1'b1, 32'h00000000}, // R2 len hi bits
        '{32'h00001ABC, 32'h00000003, 32'h00000000, 1'b1, 32'h00000000}  // R3 other vendor
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] h1, input logic [31:0] h2, input logic [31:0] b);
        req_hdr1 = h1;
        req_hdr2 = h2;
        req_body = b;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 done in reset", 32'(done), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done after reset", 32'(done), 32'h0);
        chk("R1 reject after reset", 32'(reject), 32'h0);
        chk("R1 body after reset", rsp_body, 32'h0);
        chk("R1 hdr1 after reset", rsp_hdr1, 32'h0);

        for (int v = 0; v < NV; v++) begin
            drive(VECS[v].h1, VECS[v].h2, VECS[v].body);
            chk("R8 no early done", 32'(done), 32'h0);
            @(negedge clk);
            chk("R8 done pulse", 32'(done), 32'h1);
            chk("R2/R3 reject", 32'(reject), 32'(VECS[v].rej));
            chk("R5/R6/R7 body", rsp_body, VECS[v].exp_body);
            chk("R4 hdr1", rsp_hdr1, VECS[v].rej ? 32'h0 : 32'h1);
            chk("R4 hdr2", rsp_hdr2, VECS[v].rej ? 32'h0 : 32'h3);
            @(negedge clk);
            chk("R8 done one cycle", 32'(done), 32'h0);
        end

        // R9: back-to-back starts
        req_hdr1 = 32'h1; req_hdr2 = 32'h3; req_body = 32'h0; start = 1'b1;
        @(negedge clk);
        req_body = 32'h1;
        @(negedge clk);
        chk("R9 first done", 32'(done), 32'h1);
        chk("R9 first body", rsp_body, 32'h01000001);
        req_body = 32'h2;
        @(negedge clk);
        start = 1'b0;
        chk("R9 second done", 32'(done), 32'h1);
        chk("R9 second body", rsp_body, 32'h02021ABC);
        @(negedge clk);
        chk("R9 third done", 32'(done), 32'h1);
        chk("R9 third body", rsp_body, 32'h00071ABC);

        // R11: inputs change without start
        req_hdr1 = 32'h2; req_hdr2 = 32'h7; req_body = 32'h1;
        repeat (4) begin
            @(negedge clk);
            chk("R11 no done", 32'(done), 32'h0);
            chk("R11 body held", rsp_body, 32'h00071ABC);
            chk("R11 reject held", 32'(reject), 32'h0);
        end

        // R6: full walk following next index until 0
        begin
            logic [7:0] idx = 8'h0;
            int steps = 0;
            do begin
                drive(32'h1, 32'h3, {24'h0, idx});
                @(negedge clk);
                idx = rsp_body[31:24];
                steps++;
            end while (idx != 8'h0 && steps < 10);
            chk("R6 walk length", 32'(steps), 32'd3);
        end

        finish_run();
    end
endmodule